// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block connects a UART serializer to an infrared transceiver. On the transmit side it watches the UART serial line. Each bit of value zero, start bit included, becomes one short high pulse on the infrared output. Each bit of value one leaves the infrared output low. The pulse length is a programmable count of system clocks, picked by a 3-bit select, so the pulse can be made much shorter than 3/16 of a bit.

On the receive side the infrared input is synchronized. Each rising edge holds the recovered UART line low for one full bit time, counted in ticks of the 16x bit-rate strobe. Every pulse that reaches the synchronizer counts as a zero, however narrow it is.

When the enable is low, both directions pass through unchanged, so a plain wired UART can share the same pins. The block keeps a phase count of 16x ticks, so that a run of zero bits gets one pulse per bit without any knowledge of the frame.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset with the enable high, the infrared output is low and the recovered UART line is high.
- R2: With the enable high, the first clock edge that sees the UART transmit line low after it was high starts a pulse. The infrared output is high from that edge onward.
- R3: The pulse lasts exactly 2^(sel+1) system clocks, where sel is the unsigned value of the 3-bit width select: codes 0 to 7 give 2, 4, 8, 16, 32, 64, 128 and 256 clocks.
- R4: While the transmit line stays low, a new pulse starts on the clock edge that carries the 16th tick after the previous bit began.
- R5: While the transmit line is high, no pulse is produced and the infrared output stays low.
- R6: A pulse in progress is neither extended nor restarted by a new high-to-low transition of the transmit line.
- R7: A rising edge on the infrared input drives the recovered line low from the third clock edge after the input is first sampled high. The line returns high on the clock edge that carries the 16th tick after the line went low.
- R8: An infrared pulse only one clock wide is still taken as a zero and produces the full low period of R7.
- R9: A new rising edge while the recovered line is held low restarts the 16-tick count from the new edge.
- R10: With the enable low, the infrared output equals the transmit line and the recovered line equals the infrared input, within the same cycle. Raising the enable again with both lines idle leaves both outputs at their idle levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| enable | input | 1 | High: encode and decode; low: straight pass-through |
| width_sel | input | 3 | Transmit pulse-width code, 2^(code+1) clocks |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_rxd | input | 1 | Pulse input from the infrared receiver |
| ir_txd | output | 1 | Pulse output to the infrared emitter |
| uart_rxd | output | 1 | Recovered serial data to the UART receiver |

## Verification
The transmit pulse is due one clock edge after the edge that first sees the line low. The bench drives at falling edges and checks the first falling-edge sample after that rising edge, then counts high samples until the output drops. A received pulse shows on the recovered line after three rising edges. The bench samples after the second edge (still high) and after the third (low), then counts the tick strobes it presented at each rising edge and expects the release on exactly the sample following the 16th. Bypass paths have no register, so they are checked one nanosecond after the input changes.

// File: rtl/irda_sir_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the infrared SIR codec.
// Assumes select codes are small enough that the shifted width fits 32 bits.
package irda_sir_pkg;
    // Pulse length in system clocks for a given select code.
    function automatic int unsigned pulse_cycles(input int unsigned sel, input int unsigned base_log2);
        return 32'd1 << (sel + base_log2);
    endfunction
endpackage

// File: rtl/irda_sir_tx.sv
`timescale 1ns/1ps
// Transmit encoder: turns each low UART bit into one fixed-length high pulse.
// Assumes the UART changes its line once per bit and that tick arrives
// TICKS_PER_BIT times per bit. Bit starts are taken from line transitions and
// from a running tick phase for back-to-back zero bits.
module irda_sir_tx #(
    parameter int SEL_W         = 3,
    parameter int BASE_LOG2     = 1,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             uart_txd,
    output logic             pulse_o
);
    import irda_sir_pkg::*;

    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);
    localparam int PH_W  = $clog2(TICKS_PER_BIT);

    logic             txd_q;
    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] left;
    logic             pulse_q;
    logic             changed, fall, bit_wrap, start;
    logic [CNT_W-1:0] load;

    // Decode bit-start events and the counter load value.
    always_comb begin
        changed  = (uart_txd != txd_q);
        fall     = txd_q & ~uart_txd;
        bit_wrap = tick && (phase == PH_W'(TICKS_PER_BIT - 1)) && !changed && !uart_txd;
        start    = enable && !pulse_q && (fall || bit_wrap);
        load     = CNT_W'(pulse_cycles(32'(width_sel), 32'(BASE_LOG2)) - 32'd1);
    end

    // Track the previous line level and the tick phase within the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_q <= 1'b1;
            phase <= '0;
        end else begin
            txd_q <= uart_txd;
            if (changed)
                phase <= '0;
            else if (tick)
                phase <= (phase == PH_W'(TICKS_PER_BIT - 1)) ? '0 : phase + 1'b1;
        end
    end

    // Run the pulse for the selected number of clocks, ignoring restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pulse_q <= 1'b0;
            left    <= '0;
        end else if (start) begin
            pulse_q <= 1'b1;
            left    <= load;
        end else if (pulse_q) begin
            if (left == '0)
                pulse_q <= 1'b0;
            else
                left <= left - 1'b1;
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/irda_sir_rx.sv
`timescale 1ns/1ps
// Receive decoder: synchronizes the infrared input and holds a zero flag for
// one bit time (TICKS_PER_BIT ticks) after each rising edge.
// Assumes the input is asynchronous; any pulse caught by the first flop counts.
module irda_sir_rx #(
    parameter int SYNC_STAGES   = 2,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic ir_rxd,
    output logic zero_o
);
    localparam int TC_W = $clog2(TICKS_PER_BIT);

    logic [SYNC_STAGES:0] sync_q;
    logic [TC_W-1:0]      tcnt;
    logic                 hold_q;
    logic                 rise;

    // Synchronizer chain plus one extra stage as the edge reference.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-1:0], ir_rxd};
    end

    // Rising edge seen at the synchronizer output.
    always_comb rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    // Hold the zero flag until a full bit of ticks follows the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hold_q <= 1'b0;
            tcnt   <= '0;
        end else if (rise) begin
            hold_q <= 1'b1;
            tcnt   <= '0;
        end else if (hold_q && tick) begin
            if (tcnt == TC_W'(TICKS_PER_BIT - 1)) begin
                hold_q <= 1'b0;
                tcnt   <= '0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign zero_o = hold_q;
endmodule

// File: rtl/irda_sir_codec.sv
`timescale 1ns/1ps
// Top of the infrared SIR codec: transmit encoder, receive decoder and the
// pass-through multiplexers used when the enable is low.
// Assumes tick16 is a single-cycle strobe synchronous to clk.
module irda_sir_codec #(
    parameter int SEL_W         = 3,
    parameter int BASE_LOG2     = 1,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             enable,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             uart_txd,
    input  logic             ir_rxd,
    output logic             ir_txd,
    output logic             uart_rxd
);
    logic tx_pulse;
    logic rx_zero;

    irda_sir_tx #(
        .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick16),
        .width_sel(width_sel), .uart_txd(uart_txd), .pulse_o(tx_pulse)
    );

    irda_sir_rx #(
        .SYNC_STAGES(SYNC_STAGES), .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick16),
        .ir_rxd(ir_rxd), .zero_o(rx_zero)
    );

    // Select coded or pass-through levels for both outputs.
    always_comb begin
        ir_txd   = enable ? tx_pulse : uart_txd;
        uart_rxd = enable ? ~rx_zero : ir_rxd;
    end
endmodule

// File: rtl/irda_sir_chk.sv
`timescale 1ns/1ps
// Port-level checker for the infrared SIR codec, bound to the top module.
// Assumes the parameters match those of the bound instance.
module irda_sir_chk #(
    parameter int SEL_W         = 3,
    parameter int BASE_LOG2     = 1,
    parameter int TICKS_PER_BIT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic enable,
    input logic uart_txd,
    input logic ir_rxd,
    input logic ir_txd,
    input logic uart_rxd
);
    localparam int MAX_W = 1 << ((1 << SEL_W) - 1 + BASE_LOG2);
    localparam int RUN_W = $clog2(MAX_W) + 2;
    localparam int LT_W  = $clog2(TICKS_PER_BIT) + 2;

    logic [RUN_W-1:0] hi_run;
    logic [LT_W-1:0]  lo_ticks;

    // Count consecutive coded high cycles on the infrared output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (enable && ir_txd && hi_run != {RUN_W{1'b1}})
            hi_run <= hi_run + 1'b1;
        else if (!(enable && ir_txd))
            hi_run <= '0;
    end

    // Count ticks seen while the recovered line is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_ticks <= '0;
        else if (uart_rxd)
            lo_ticks <= '0;
        else if (tick16 && lo_ticks != {LT_W{1'b1}})
            lo_ticks <= lo_ticks + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!enable || (!ir_txd && uart_rxd))); // R1
    AST_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ir_txd) && enable && $past(enable)) |-> !$past(uart_txd)); // R2
    AST_PULSE_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ir_txd) |-> (hi_run < RUN_W'(MAX_W))); // R3
    AST_RX_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uart_rxd) && enable && $past(enable)) |-> $past(ir_rxd, 3)); // R7
    AST_RX_FULL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(uart_rxd) && enable && $past(enable)) |-> (lo_ticks >= LT_W'(TICKS_PER_BIT))); // R9
    AST_BYPASS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (ir_txd == uart_txd)); // R10
    AST_BYPASS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (uart_rxd == ir_rxd)); // R10
endmodule

bind irda_sir_codec irda_sir_chk #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .TICKS_PER_BIT(TICKS_PER_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .enable(enable),
    .uart_txd(uart_txd), .ir_rxd(ir_rxd), .ir_txd(ir_txd), .uart_rxd(uart_rxd)
);

// File: tb/sim_irda_sir_codec.sv
`timescale 1ns/1ps
module sim_irda_sir_codec;
    localparam int TDIV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       enable = 1'b1;
    logic [2:0] width_sel = 3'd0;
    logic       uart_txd = 1'b1;
    logic       ir_rxd = 1'b0;
    logic       ir_txd;
    logic       uart_rxd;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    irda_sir_codec u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .enable(enable),
        .width_sel(width_sel), .uart_txd(uart_txd), .ir_rxd(ir_rxd),
        .ir_txd(ir_txd), .uart_rxd(uart_rxd)
    );

    always #2 clk = ~clk;

    // Tick strobe: one cycle high every TDIV clocks, changed at falling edges.
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = tc + 1;
            tick16 = (tc % TDIV == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks = checks + 1;
        if (act != exp) begin
            errs = errs + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1: idle levels right after reset.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", ir_txd, 0, "ir_txd after reset");
        chk("R1", uart_rxd, 1, "uart_rxd after reset");
    endtask

    // R2/R3/R5: one zero bit at a given width code.
    task automatic t_width(input int sel);
        int n = 0;
        width_sel = sel[2:0];
        uart_txd = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5", ir_txd, 0, "idle before zero bit");
        uart_txd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2", ir_txd, 1, "pulse after first low edge");
        while (ir_txd && n < 400) begin
            n = n + 1;
            @(negedge clk);
        end
        chk("R3", n, 2 << sel, $sformatf("pulse length code %0d", sel));
        uart_txd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // R5: two bit times of ones give no pulse.
    task automatic t_ones();
        int hi = 0;
        uart_txd = 1'b1;
        repeat (2 * 16 * TDIV) begin
            @(negedge clk);
            if (ir_txd) hi = hi + 1;
        end
        chk("R5", hi, 0, "high samples during ones");
    endtask

    // R4: second zero bit pulses on the 16th tick after the first bit start.
    task automatic t_two_zeros();
        int ticks = 0;
        int prev = 1;
        width_sel = 3'd0;
        uart_txd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        while (ticks < 16) begin
            prev = ir_txd;
            @(posedge clk);
            if (tick16) ticks = ticks + 1;
            @(negedge clk);
        end
        chk("R4", prev, 0, "low before second bit");
        chk("R4", ir_txd, 1, "pulse at second bit start");
        uart_txd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // R6: a new falling edge inside a pulse does not stretch it.
    task automatic t_no_retrigger();
        int n = 0;
        width_sel = 3'd3;
        uart_txd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        while (ir_txd && n < 400) begin
            n = n + 1;
            if (n == 4) uart_txd = 1'b1;
            if (n == 5) uart_txd = 1'b0;
            @(negedge clk);
        end
        chk("R6", n, 16, "pulse length with inner toggle");
        uart_txd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // R7/R8/R9: drive a receive pulse of len clocks, then follow the low period.
    task automatic rx_follow(input string req, input int len, input bit was_low, input int stop_at);
        int ticks = 0;
        ir_rxd = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == len) ir_rxd = 1'b0;
            if (k < 3) chk(req, uart_rxd, was_low ? 0 : 1, "before third edge");
            else       chk(req, uart_rxd, 0, "low at third edge");
        end
        while (ticks < stop_at) begin
            @(posedge clk);
            if (tick16) ticks = ticks + 1;
            @(negedge clk);
            if (ticks < 16) begin
                if (uart_rxd !== 1'b0) chk(req, uart_rxd, 0, $sformatf("held low at tick %0d", ticks));
            end else begin
                chk(req, uart_rxd, 1, "release at 16th tick");
            end
        end
        if (stop_at == 16) chk(req, ticks, 16, "ticks to release");
    endtask

    // R10: pass-through both ways, then clean return to coded mode.
    task automatic t_bypass();
        enable = 1'b0;
        uart_txd = 1'b0;
        #1 chk("R10", ir_txd, 0, "bypass tx low");
        uart_txd = 1'b1;
        #1 chk("R10", ir_txd, 1, "bypass tx high");
        ir_rxd = 1'b1;
        #1 chk("R10", uart_rxd, 1, "bypass rx high");
        ir_rxd = 1'b0;
        #1 chk("R10", uart_rxd, 0, "bypass rx low");
        repeat (5) @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", ir_txd, 0, "ir_txd after re-enable");
        chk("R10", uart_rxd, 1, "uart_rxd after re-enable");
    endtask

    initial begin
        t_reset();
        for (int s = 0; s < 8; s++) t_width(s);
        t_ones();
        t_two_zeros();
        t_no_retrigger();
        rx_follow("R7", 2, 1'b0, 16);
        repeat (10) @(negedge clk);
        rx_follow("R8", 1, 1'b0, 16);
        repeat (10) @(negedge clk);
        rx_follow("R9", 2, 1'b0, 5);
        rx_follow("R9", 2, 1'b1, 16);
        repeat (10) @(negedge clk);
        t_bypass();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks = checks + 1;
            errs = errs + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule